// File: doc/BRIEF.md
# Firmware Hub Write-Cycle Target

This block sits on the target side of a 4-bit LPC bus and accepts firmware-hub-style write cycles. It watches the framing strobe `lframe_ni` and the nibble lane `lad_i`. When it sees the write start code, it checks the following nibble against a configured identity. On a match it collects the address and the data byte. After the host's turnaround it answers with a one-clock "ready" SYNC, drives the lane high for one clock and then releases the bus.

Each accepted cycle produces one write beat on the output side, made up of a 32-bit address and an 8-bit data byte, plus a one-clock host-access wake pulse. The write beat is valid-only: `wr_valid_o` is high for exactly one clock and there is no ready input. The bus cannot be stalled once SYNC is reported, so the consumer must take every beat in the cycle it is shown. An identity mismatch, a new framing strobe part-way through, a power-down request or reset each drop the cycle silently, and the lane is never driven in those cases.

Top module: `fwh_write_target`

## Requirements
- R1: A cycle begins only at a clock where `lframe_ni` is low and `lad_i` is 4'b1110. The last low-frame clock decides: a low-frame clock carrying any other code leaves the block idle, and the block does not respond to the cycle that follows it.
- R2: The first nibble after the start code is compared with `cfg_id_i`, which carries bits 7-4 of the shared-memory configuration register. On a mismatch the block gives no write beat and no wake pulse, and keeps `lad_oe_o` low for the rest of that cycle.
- R3: Eight address nibbles follow the identity nibble, most significant first. Nibbles one to seven become address bits 27..0, with nibble one at bits 27..24 and nibble seven at bits 3..0. The eighth nibble has no effect on the reported address.
- R4: Bits 31..28 of `wr_addr_o` read 4'b1111 whenever `wr_valid_o` is high.
- R5: Two data nibbles follow the address. The first is placed at `wr_data_o[3:0]` and the second at `wr_data_o[7:4]`.
- R6: During the receive phases and during the two host turnaround clocks after the data, `lad_oe_o` stays low. On the clock after those turnaround clocks the block drives `lad_o` = 4'b0000 with `lad_oe_o` high, which is the ready SYNC.
- R7: `wr_valid_o` is high for exactly one clock per accepted cycle, in the SYNC clock, with `wr_addr_o` and `wr_data_o` valid in that same clock. There is no back-pressure.
- R8: `wake_o` pulses high for exactly one clock, in the SYNC clock, for each accepted cycle and never otherwise.
- R9: In the clock after SYNC the block drives `lad_o` = 4'b1111 with `lad_oe_o` high. In the clock after that `lad_oe_o` is low and stays low until the next accepted SYNC.
- R10: A low `lframe_ni` at any clock of a cycle before SYNC aborts it with no write beat and no wake pulse. The next start code is accepted at once.
- R11: While `rst_ni` is low, or at any clock where `pwr_down_i` is high, `lad_oe_o`, `wr_valid_o` and `wake_o` are low. A cycle that is interrupted this way produces no write beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_down_i | input | 1 | Bus power-down request, forces idle |
| cfg_id_i | input | 4 | Identity to match (configuration register bits 7-4) |
| lframe_ni | input | 1 | Framing strobe, active low |
| lad_i | input | 4 | Nibble lane as seen from the bus |
| lad_o | output | 4 | Nibble value driven onto the lane |
| lad_oe_o | output | 1 | Output enable for `lad_o` |
| wr_valid_o | output | 1 | One-clock write beat strobe |
| wr_addr_o | output | 32 | Write address, bits 31..28 forced high |
| wr_data_o | output | 8 | Write data byte |
| wake_o | output | 1 | One-clock host-access wake pulse |

## Verification
Write cycles are driven with matching and mismatching identities. The mismatching identity is taken from the low half of the configuration byte, which tells apart a comparison made against the wrong nibble. Address patterns with distinct nibbles, all ones and all zeros, each with a differing eighth nibble, expose nibble order, the discarded nibble and the forced top bits. Data bytes with unequal halves show the low-first assembly. Directed cycles with a wrong start code, a start held for two low-frame clocks, aborts at several phases, and power-down part-way through confirm that the block stays silent and then recovers for the next cycle.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

  localparam int unsigned NIB_W = 4;

  localparam logic [NIB_W-1:0] START_WRITE = 4'b1110;
  localparam logic [NIB_W-1:0] SYNC_READY  = 4'b0000;
  localparam logic [NIB_W-1:0] LANE_HIGH   = 4'b1111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_DATA,
    ST_TAR_IN,
    ST_SYNC,
    ST_TAR_DRV,
    ST_TAR_OFF
  } fwh_state_e;

endpackage

// File: rtl/fwh_frame_fsm.sv
module fwh_frame_fsm
  import fwh_pkg::*;
#(
  parameter int unsigned ADDR_NIBBLES = 8,
  parameter int unsigned USED_NIBBLES = 7,
  parameter int unsigned DATA_NIBBLES = 2,
  parameter int unsigned TAR_CYCLES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_down_i,
  input  logic             lframe_ni,
  input  logic [NIB_W-1:0] lad_i,
  input  logic [NIB_W-1:0] cfg_id_i,
  output fwh_state_e       state_o,
  output logic             addr_en_o,
  output logic             data_en_o
);

  localparam int unsigned CNT_MAX = (ADDR_NIBBLES > DATA_NIBBLES) ?
                                    ((ADDR_NIBBLES > TAR_CYCLES) ? ADDR_NIBBLES : TAR_CYCLES) :
                                    ((DATA_NIBBLES > TAR_CYCLES) ? DATA_NIBBLES : TAR_CYCLES);
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_NIBBLES - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_NIBBLES - 1);
  localparam logic [CNT_W-1:0] LAST_TAR  = CNT_W'(TAR_CYCLES - 1);
  localparam logic [CNT_W-1:0] USED_LIM  = CNT_W'(USED_NIBBLES);

  fwh_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (pwr_down_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (!lframe_ni) begin
      st_q  <= (lad_i == START_WRITE) ? ST_ID : ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
        end
        ST_ID: begin
          st_q  <= (lad_i == cfg_id_i) ? ST_ADDR : ST_IDLE;
          cnt_q <= '0;
        end
        ST_ADDR: begin
          if (cnt_q == LAST_ADDR) begin
            st_q  <= ST_DATA;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == LAST_DATA) begin
            st_q  <= ST_TAR_IN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TAR_IN: begin
          if (cnt_q == LAST_TAR) begin
            st_q  <= ST_SYNC;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SYNC:    st_q <= ST_TAR_DRV;
        ST_TAR_DRV: st_q <= ST_TAR_OFF;
        ST_TAR_OFF: st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = st_q;
  assign addr_en_o = (st_q == ST_ADDR) && (cnt_q < USED_LIM);
  assign data_en_o = (st_q == ST_DATA);

  AST_ID_MISMATCH_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ID && lframe_ni && !pwr_down_i && lad_i != cfg_id_i) |=> st_q == ST_IDLE); // R2

  AST_FRAME_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lframe_ni && lad_i != START_WRITE) |=> st_q == ST_IDLE); // R10

  AST_PD_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> st_q == ST_IDLE); // R11

  AST_SYNC_AFTER_TAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SYNC) |-> $past(st_q) == ST_TAR_IN); // R6

endmodule

// File: rtl/fwh_capture.sv
module fwh_capture
  import fwh_pkg::*;
#(
  parameter int unsigned USED_NIBBLES = 7,
  parameter int unsigned DATA_W       = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    addr_en_i,
  input  logic                    data_en_i,
  input  logic [NIB_W-1:0]        lad_i,
  output logic [USED_NIBBLES*NIB_W-1:0] addr_o,
  output logic [DATA_W-1:0]       data_o
);

  localparam int unsigned USED_W = USED_NIBBLES * NIB_W;

  logic [USED_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // Address arrives most significant nibble first: shift in at the bottom.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (addr_en_i) addr_q <= {addr_q[USED_W-NIB_W-1:0], lad_i};
  end

  // Data arrives least significant nibble first: shift in at the top.
  generate
    if (DATA_W > NIB_W) begin : g_multi_nib
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        data_q <= '0;
        else if (data_en_i) data_q <= {lad_i, data_q[DATA_W-1:NIB_W]};
      end
    end else begin : g_single_nib
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        data_q <= '0;
        else if (data_en_i) data_q <= lad_i[DATA_W-1:0];
      end
    end
  endgenerate

  assign addr_o = addr_q;
  assign data_o = data_q;

  AST_ADDR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_en_i |=> $stable(addr_q)); // R3

endmodule

// File: rtl/fwh_lad_drive.sv
module fwh_lad_drive
  import fwh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_down_i,
  input  fwh_state_e       state_i,
  output logic [NIB_W-1:0] lad_o,
  output logic             lad_oe_o,
  output logic             strobe_o,
  output logic             wake_o
);

  logic in_sync;
  logic in_drv;

  assign in_sync  = (state_i == ST_SYNC) && !pwr_down_i;
  assign in_drv   = (state_i == ST_TAR_DRV) && !pwr_down_i;

  assign lad_oe_o = in_sync || in_drv;
  assign lad_o    = in_sync ? SYNC_READY : LANE_HIGH;
  assign strobe_o = in_sync;
  assign wake_o   = in_sync;

  AST_HIGH_THEN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lad_oe_o && lad_o == LANE_HIGH) |=> !lad_oe_o); // R9

  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R8

endmodule

// File: rtl/fwh_write_target.sv
module fwh_write_target
  import fwh_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned ADDR_NIBBLES = 8,
  parameter int unsigned USED_NIBBLES = 7,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned TAR_CYCLES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_down_i,
  input  logic [3:0]        cfg_id_i,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wake_o
);

  localparam int unsigned USED_W       = USED_NIBBLES * NIB_W;
  localparam int unsigned DATA_NIBBLES = (DATA_W + NIB_W - 1) / NIB_W;
  localparam int unsigned PAD_W        = ADDR_W - USED_W;

  fwh_state_e        state;
  logic              addr_en;
  logic              data_en;
  logic [USED_W-1:0] addr_low;

  fwh_frame_fsm #(
    .ADDR_NIBBLES (ADDR_NIBBLES),
    .USED_NIBBLES (USED_NIBBLES),
    .DATA_NIBBLES (DATA_NIBBLES),
    .TAR_CYCLES   (TAR_CYCLES)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_down_i (pwr_down_i),
    .lframe_ni  (lframe_ni),
    .lad_i      (lad_i),
    .cfg_id_i   (cfg_id_i),
    .state_o    (state),
    .addr_en_o  (addr_en),
    .data_en_o  (data_en)
  );

  fwh_capture #(
    .USED_NIBBLES (USED_NIBBLES),
    .DATA_W       (DATA_W)
  ) i_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_en_i (addr_en),
    .data_en_i (data_en),
    .lad_i     (lad_i),
    .addr_o    (addr_low),
    .data_o    (wr_data_o)
  );

  fwh_lad_drive i_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_down_i (pwr_down_i),
    .state_i    (state),
    .lad_o      (lad_o),
    .lad_oe_o   (lad_oe_o),
    .strobe_o   (wr_valid_o),
    .wake_o     (wake_o)
  );

  assign wr_addr_o = {{PAD_W{1'b1}}, addr_low};

  AST_TOP_NIBBLE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_addr_o[ADDR_W-1 -: 4] == 4'hF); // R4

  AST_STROBE_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o); // R7

  AST_STROBE_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (lad_oe_o && lad_o == SYNC_READY)); // R6

  AST_NO_STROBE_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_ni |=> !wr_valid_o); // R10

  AST_PD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> (!lad_oe_o && !wr_valid_o && !wake_o)); // R11

endmodule

// File: tb/test_fwh_write_target.sv
`timescale 1ns/1ps
module test_fwh_write_target;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd = 1'b0;
  logic [3:0]  cfg_id = 4'hA;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fwh_write_target i_fwh_write_target (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pwr_down_i (pd),
    .cfg_id_i   (cfg_id),
    .lframe_ni  (lframe_n),
    .lad_i      (lad),
    .lad_o      (lad_out),
    .lad_oe_o   (lad_oe),
    .wr_valid_o (wr_valid),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .wake_o     (wake)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Slots after the start clock: 0 id, 1..8 address, 9..10 data,
  // 11..12 host turnaround, 13 SYNC, 14 drive-high, 15 released.
  // cut >= 0 disturbs the cycle at that slot: frame low (abort) or power-down.
  task automatic run_xfer(input logic [3:0] start, input bit pre, input logic [3:0] id,
                          input logic [31:0] anib, input logic [7:0] dat, input bit hit,
                          input int cut, input bit cut_pd, input string req);
    int stray = 0;
    logic [31:0] exp_addr;
    exp_addr = {4'hF, anib[31:4]};
    if (pre) begin
      @(negedge clk); lframe_n = 1'b0; lad = 4'h0;
    end
    @(negedge clk); lframe_n = 1'b0; lad = start;
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      if (s == 13 && hit) begin
        chk(wr_valid === 1'b1, "R7", {req, " strobe in SYNC"}, 32'(wr_valid), 1);
        chk(lad_oe === 1'b1 && lad_out === 4'h0, "R6", {req, " ready SYNC"},
            {27'(0), lad_oe, lad_out}, 32'h10);
        chk(wr_addr === exp_addr, "R3", {req, " address"}, wr_addr, exp_addr);
        chk(wr_addr[31:28] === 4'hF, "R4", {req, " top nibble"}, 32'(wr_addr[31:28]), 32'hF);
        chk(wr_data === dat, "R5", {req, " data"}, 32'(wr_data), 32'(dat));
        chk(wake === 1'b1, "R8", {req, " wake"}, 32'(wake), 1);
      end else if (s == 14 && hit) begin
        chk(lad_oe === 1'b1 && lad_out === 4'hF && !wr_valid && !wake, "R9",
            {req, " drive high"}, {26'(0), wr_valid, lad_oe, lad_out}, 32'h1F);
      end else if (wr_valid !== 1'b0 || wake !== 1'b0 || lad_oe !== 1'b0) begin
        stray++;
      end
      lframe_n = 1'b1;
      pd = 1'b0;
      if (s == cut) begin
        if (cut_pd) pd = 1'b1;
        else begin lframe_n = 1'b0; lad = 4'h0; end
      end
      if (!(s == cut && !cut_pd)) begin
        if (s == 0)       lad = id;
        else if (s <= 8)  lad = anib[35-4*s -: 4];
        else if (s == 9)  lad = dat[3:0];
        else if (s == 10) lad = dat[7:4];
        else              lad = 4'hF;
      end
    end
    chk(stray == 0, req, "no stray drive, strobe or wake", stray, 0);
  endtask

  // {hit, id, address nibbles, data}
  localparam logic [44:0] VEC [6] = '{
    {1'b1, 4'hA, 32'h1234_5678, 8'h3C},
    {1'b1, 4'hA, 32'hFFFF_FFF0, 8'hFF},
    {1'b1, 4'hA, 32'h0000_000F, 8'h00},
    {1'b0, 4'h5, 32'h1357_9BDF, 8'h5A},
    {1'b1, 4'hA, 32'hA5A5_5A5A, 8'h81},
    {1'b0, 4'hB, 32'h2468_ACE0, 8'h96}
  };

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!lad_oe && !wr_valid && !wake, "R11", "quiet in reset",
        {29'(0), lad_oe, wr_valid, wake}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table: match and mismatch (R1, R2, R3, R4, R5, R6, R7, R8, R9)
    for (int v = 0; v < 6; v++) begin
      run_xfer(4'hE, 1'b0, VEC[v][43:40], VEC[v][39:8], VEC[v][7:0], VEC[v][44],
               -1, 1'b0, VEC[v][44] ? "R1" : "R2");
    end

    // R1: wrong start code is ignored
    run_xfer(4'hD, 1'b0, 4'hA, 32'h1111_1111, 8'h11, 1'b0, -1, 1'b0, "R1");
    // R1: start held two low-frame clocks, last one decides
    run_xfer(4'hE, 1'b1, 4'hA, 32'h7654_3210, 8'hE7, 1'b1, -1, 1'b0, "R1");
    // R10: aborts at identity, mid-address, data, turnaround; then restart
    run_xfer(4'hE, 1'b0, 4'hA, 32'h2222_2222, 8'h22, 1'b0, 0, 1'b0, "R10");
    run_xfer(4'hE, 1'b0, 4'hA, 32'h3333_3333, 8'h33, 1'b0, 4, 1'b0, "R10");
    run_xfer(4'hE, 1'b0, 4'hA, 32'h4444_4444, 8'h44, 1'b0, 9, 1'b0, "R10");
    run_xfer(4'hE, 1'b0, 4'hA, 32'h5555_5555, 8'h55, 1'b0, 12, 1'b0, "R10");
    run_xfer(4'hE, 1'b0, 4'hA, 32'h89AB_CDEF, 8'hC3, 1'b1, -1, 1'b0, "R10");
    // R11: power-down mid-address and in turnaround, then recover
    run_xfer(4'hE, 1'b0, 4'hA, 32'h6666_6666, 8'h66, 1'b0, 5, 1'b1, "R11");
    run_xfer(4'hE, 1'b0, 4'hA, 32'h7777_7777, 8'h77, 1'b0, 11, 1'b1, "R11");
    run_xfer(4'hE, 1'b0, 4'hA, 32'h0F1E_2D3C, 8'h4B, 1'b1, -1, 1'b0, "R11");
    // R2: new identity from configuration
    cfg_id = 4'h3;
    run_xfer(4'hE, 1'b0, 4'hA, 32'h1234_5678, 8'h12, 1'b0, -1, 1'b0, "R2");
    run_xfer(4'hE, 1'b0, 4'h3, 32'hFEDC_BA98, 8'h7E, 1'b1, -1, 1'b0, "R2");
    // R11: asynchronous reset mid-cycle
    @(negedge clk); lframe_n = 1'b0; lad = 4'hE;
    @(negedge clk); lframe_n = 1'b1; lad = 4'h3;
    @(negedge clk); lad = 4'h1;
    #1 rst_n = 1'b0;
    #1 chk(!lad_oe && !wr_valid && !wake, "R11", "quiet after async reset",
           {29'(0), lad_oe, wr_valid, wake}, 0);
    @(negedge clk); rst_n = 1'b1;
    run_xfer(4'hE, 1'b0, 4'h3, 32'h0102_0304, 8'hA0, 1'b1, -1, 1'b0, "R11");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule